// File: doc/BRIEF.md
# Synchronous Serial Port Controller with Paired FIFOs

This block is a register-mapped synchronous serial port controller. Software writes transmit words through a data register into an 8-entry transmit queue. A small exchange engine takes one queued word at a time and trades it for a received word. It does this either over an external frame port, which uses a request/acknowledge handshake and leaves bit timing to a separate serializer, or through an internal loopback path. The received word, trimmed to the programmed data size, goes into an 8-entry receive queue, and software reads it back through the same data register.

The engine never overruns the receive queue. When the receive queue is full, transmission stalls until software reads a word. Status flags and raw interrupt flags are computed every cycle from the two fill counters. A single level interrupt is raised when any raw flag is enabled by the interrupt mask.

The engine has two states. In `XS_IDLE` it can take the LOOP transition: in loopback mode it pops a transmit word and pushes the received copy in the same cycle, and stays in `XS_IDLE`. It can instead take the LAUNCH transition: it pops a transmit word, latches it and moves to `XS_WAIT`. In `XS_WAIT` the frame request is held. The DONE transition, taken on acknowledge, pushes the returned word and goes back to `XS_IDLE`.

Top module: `ssp_ctrl`

## Requirements
- R1: After reset, status reads 0x03, raw interrupt status reads 0x08, the mask reads 0, `irq` is low and control 0 reads 0x0007.
- R2: The registers are at word index 0 (control 0, full width), 1 (control 1, bits [3:0] kept), 2 (data), 3 (status), 4 (prescale, low 8 bits kept), 5 (interrupt mask, low 4 bits kept), 6 (raw interrupt), 7 (masked interrupt) and 8 (DMA control). Index 8 reads 0 and ignores writes.
- R3: Control 0 bits [3:0] give the data size minus one. A word written to the transmit queue is ANDed with a mask of that many low ones, and so is every word stored into the receive queue, using the size in force at the moment of storing.
- R4: When control 1 bit 0 (loopback) and bit 1 (enable) are both set, each transmit word returns unchanged as the received word, and `frm_req` never rises.
- R5: With enable set and loopback clear, the engine drives `frm_req` with the word on `frm_tx`. It holds both until `frm_ack` and keeps only one exchange outstanding. On acknowledge it stores `frm_rx`, masked, into the receive queue.
- R6: While enable (control 1 bit 1) is clear, no exchange starts and transmit words stay queued.
- R7: A data write while the transmit queue holds 8 words is discarded.
- R8: The engine pauses while the receive queue holds 8 words. After a data read frees a slot, it exchanges the next word.
- R9: A data read while the receive queue is empty returns 0 and changes no state.
- R10: Status bits: 0 = transmit queue empty, 1 = transmit queue not full, 2 = receive queue not empty, 3 = receive queue full, 4 = busy (transmit queue not empty).
- R11: Raw interrupt bit 2 is set while the receive fill level is at least 4. Bit 3 is set while the transmit fill level is at most 4. Bits 1 and 0 read 0.
- R12: Masked interrupt status equals raw status AND mask, and `irq` is high exactly when that value is nonzero.
- R13: Both queues deliver words in first-in, first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register word index |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops the receive queue on a data read) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from `bus_addr` |
| irq | output | 1 | Level interrupt |
| frm_req | output | 1 | Frame exchange request |
| frm_tx | output | DATA_W | Word to send, valid with `frm_req` |
| frm_ack | input | 1 | Frame exchange complete |
| frm_rx | input | DATA_W | Received word, valid with `frm_ack` |

## Verification
The bench uses the default parameters: 16-bit words, 8-entry queues and 8-bit prescale. At these values it can fill the transmit queue and overflow it while the port is disabled, and fill the receive queue to 8 so that the stall and the one-word resume after each read can be observed. The thresholds of 4 fall inside short directed sequences. Because the size field can span 1 to 16 bits, the bench can check truncation on both the write path and the store path, including a size change made while words are still queued.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;
    typedef enum logic {XS_IDLE, XS_WAIT} xs_e;

    localparam int unsigned REG_CTL0 = 0;
    localparam int unsigned REG_CTL1 = 1;
    localparam int unsigned REG_DATA = 2;
    localparam int unsigned REG_STAT = 3;
    localparam int unsigned REG_PSC  = 4;
    localparam int unsigned REG_MASK = 5;
    localparam int unsigned REG_RAW  = 6;
    localparam int unsigned REG_MIS  = 7;
    localparam int unsigned REG_DMA  = 8;

    localparam int unsigned C1_LOOP = 0;
    localparam int unsigned C1_EN   = 1;
endpackage

// File: rtl/ssp_fifo.sv
`timescale 1ns/1ps
module ssp_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  logic [W-1:0]               wdata,
    output logic [W-1:0]               rdata,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wdata;
    end

    assign rdata = mem[rptr];

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (count != CNT_W'(DEPTH))); // R7
    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0)); // R9
endmodule

// File: rtl/ssp_xchg.sv
`timescale 1ns/1ps
module ssp_xchg import ssp_pkg::*; #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              loop,
    input  logic              tx_empty,
    input  logic              rx_full,
    input  logic [DATA_W-1:0] tx_head,
    input  logic [DATA_W-1:0] size_mask,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_word,
    output logic              frm_req,
    output logic [DATA_W-1:0] frm_tx,
    input  logic              frm_ack,
    input  logic [DATA_W-1:0] frm_rx
);
    xs_e              state, nxt;
    logic [DATA_W-1:0] word_q;
    logic              go;

    assign go = en && !tx_empty && !rx_full;

    always_comb begin
        nxt = state;
        unique case (state)
            XS_IDLE: if (go && !loop) nxt = XS_WAIT;   // LAUNCH
            XS_WAIT: if (frm_ack)     nxt = XS_IDLE;   // DONE
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= XS_IDLE;
            word_q <= '0;
        end else begin
            state <= nxt;
            if (state == XS_IDLE && go && !loop) word_q <= tx_head;
        end
    end

    always_comb begin
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        rx_word = tx_head & size_mask;
        frm_req = 1'b0;
        frm_tx  = word_q;
        unique case (state)
            XS_IDLE: begin
                tx_pop  = go;
                rx_push = go && loop;                  // LOOP
            end
            XS_WAIT: begin
                frm_req = 1'b1;
                rx_push = frm_ack;
                rx_word = frm_rx & size_mask;
            end
        endcase
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_req && !frm_ack) |=> (frm_req && $stable(frm_tx))); // R5
    AST_LOOP_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (loop && !frm_req) |=> !frm_req); // R4
    AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full); // R8
endmodule

// File: rtl/ssp_ctrl.sv
`timescale 1ns/1ps
module ssp_ctrl import ssp_pkg::*; #(
    parameter int DATA_W   = 16,
    parameter int DEPTH    = 8,
    parameter int ADDR_W   = 4,
    parameter int PSC_W    = 8,
    parameter int CTL0_RST = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              frm_req,
    output logic [DATA_W-1:0] frm_tx,
    input  logic              frm_ack,
    input  logic [DATA_W-1:0] frm_rx
);
    localparam int SIZE_W = $clog2(DATA_W);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] THR_C  = CNT_W'(DEPTH / 2);
    localparam logic [ADDR_W-1:0] A_CTL0 = ADDR_W'(REG_CTL0);
    localparam logic [ADDR_W-1:0] A_CTL1 = ADDR_W'(REG_CTL1);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(REG_DATA);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);
    localparam logic [ADDR_W-1:0] A_PSC  = ADDR_W'(REG_PSC);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(REG_MASK);
    localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(REG_RAW);
    localparam logic [ADDR_W-1:0] A_MIS  = ADDR_W'(REG_MIS);

    logic [DATA_W-1:0] ctl0_q;
    logic [3:0]        ctl1_q;
    logic [PSC_W-1:0]  psc_q;
    logic [3:0]        imask_q;

    logic [DATA_W-1:0] size_mask, tx_head, rx_head, rx_word;
    logic [CNT_W-1:0]  tx_cnt, rx_cnt;
    logic              tx_push, tx_pop, rx_push, rx_pop;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic [4:0]        status_w;
    logic [3:0]        raw_w;

    assign size_mask = {DATA_W{1'b1}} >> (SIZE_W'(DATA_W - 1) - ctl0_q[SIZE_W-1:0]);

    assign tx_empty = (tx_cnt == '0);
    assign tx_full  = (tx_cnt == FULL_C);
    assign rx_empty = (rx_cnt == '0);
    assign rx_full  = (rx_cnt == FULL_C);

    assign tx_push = bus_wr && (bus_addr == A_DATA) && !tx_full;
    assign rx_pop  = bus_rd && (bus_addr == A_DATA) && !rx_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl0_q  <= DATA_W'(CTL0_RST);
            ctl1_q  <= '0;
            psc_q   <= '0;
            imask_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_CTL0) ctl0_q  <= bus_wdata;
            if (bus_addr == A_CTL1) ctl1_q  <= bus_wdata[3:0];
            if (bus_addr == A_PSC)  psc_q   <= bus_wdata[PSC_W-1:0];
            if (bus_addr == A_MASK) imask_q <= bus_wdata[3:0];
        end
    end

    ssp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop),
        .wdata(bus_wdata & size_mask), .rdata(tx_head), .count(tx_cnt));

    ssp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop),
        .wdata(rx_word), .rdata(rx_head), .count(rx_cnt));

    ssp_xchg #(.DATA_W(DATA_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .en(ctl1_q[C1_EN]), .loop(ctl1_q[C1_LOOP]),
        .tx_empty(tx_empty), .rx_full(rx_full),
        .tx_head(tx_head), .size_mask(size_mask),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
        .frm_req(frm_req), .frm_tx(frm_tx),
        .frm_ack(frm_ack), .frm_rx(frm_rx));

    assign status_w = {!tx_empty, rx_full, !rx_empty, !tx_full, tx_empty};
    assign raw_w    = {tx_cnt <= THR_C, rx_cnt >= THR_C, 2'b00};
    assign irq      = |(raw_w & imask_q);

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTL0: bus_rdata = ctl0_q;
            A_CTL1: bus_rdata = DATA_W'(ctl1_q);
            A_DATA: bus_rdata = rx_empty ? '0 : rx_head;
            A_STAT: bus_rdata = DATA_W'(status_w);
            A_PSC:  bus_rdata = DATA_W'(psc_q);
            A_MASK: bus_rdata = DATA_W'(imask_q);
            A_RAW:  bus_rdata = DATA_W'(raw_w);
            A_MIS:  bus_rdata = DATA_W'(raw_w & imask_q);
            default: bus_rdata = '0;
        endcase
    end

    AST_NO_XFER_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl1_q[C1_EN] && !frm_req) |=> (tx_cnt >= $past(tx_cnt))); // R6
    AST_RX_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= FULL_C); // R8
endmodule

// File: tb/ssp_ctrl_bench.sv
`timescale 1ns/1ps
module ssp_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;
    logic        frm_req;
    logic [15:0] frm_tx;
    logic        frm_ack = 1'b0;
    logic [15:0] frm_rx = '0;

    int  n_chk = 0;
    int  n_bad = 0;
    int  req_cycles = 0;
    bit  resp_on = 1'b0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    ssp_ctrl u_ssp_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .frm_req(frm_req), .frm_tx(frm_tx),
        .frm_ack(frm_ack), .frm_rx(frm_rx));

    initial begin
        forever begin
            @(negedge clk);
            if (resp_on && frm_req && !frm_ack) begin
                frm_ack = 1'b1;
                frm_rx  = frm_tx ^ 16'hFFFF;
            end else begin
                frm_ack = 1'b0;
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            if (frm_req) req_cycles++;
        end
    end

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = 4'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] v);
        @(negedge clk);
        bus_addr = 4'(a); bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input int a, input logic [15:0] exp, input string tag);
        logic [15:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic t_reset();
        rd_chk(3, 16'h0003, "R1 status");
        rd_chk(6, 16'h0008, "R1 raw");
        rd_chk(5, 16'h0000, "R1 mask");
        rd_chk(0, 16'h0007, "R1 ctl0");
        chk("R1 irq", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_regs();
        wr(0, 16'h00F5); rd_chk(0, 16'h00F5, "R2 ctl0");
        wr(4, 16'h1ABC); rd_chk(4, 16'h00BC, "R2 prescale");
        wr(5, 16'h00FF); rd_chk(5, 16'h000F, "R2 mask");
        wr(1, 16'h00F0); rd_chk(1, 16'h0000, "R2 ctl1");
        wr(8, 16'h0001); rd_chk(8, 16'h0000, "R2 dma");
        wr(5, 16'h0000);
        wr(0, 16'h000F);
    endtask

    task automatic t_disabled();
        for (int i = 0; i < 3; i++) wr(2, 16'h1000 + 16'(i));
        idle(4);
        rd_chk(3, 16'h0012, "R6 R10 status three queued");
        rd_chk(6, 16'h0008, "R11 raw tx at 3");
        wr(2, 16'h1003); wr(2, 16'h1004);
        rd_chk(6, 16'h0000, "R11 raw tx at 5");
        for (int i = 5; i < 9; i++) wr(2, 16'h1000 + 16'(i));
        idle(4);
        rd_chk(3, 16'h0010, "R7 R10 status tx full");
        rd_chk(2, 16'h0000, "R9 empty read");
        rd_chk(3, 16'h0010, "R9 status unchanged");
    endtask

    task automatic t_loop();
        req_cycles = 0;
        wr(1, 16'h0003);
        idle(12);
        rd_chk(3, 16'h000F, "R4 R10 status rx full");
        rd_chk(6, 16'h000C, "R11 raw rx full tx empty");
        for (int i = 0; i < 8; i++) rd_chk(2, 16'h1000 + 16'(i), "R4 R13 loop order");
        rd_chk(2, 16'h0000, "R7 ninth word dropped");
        rd_chk(3, 16'h0003, "R10 status drained");
        chk("R4 no request", 16'(req_cycles), 16'h0000);
    endtask

    task automatic t_mask();
        wr(1, 16'h0000);
        wr(0, 16'h0003);
        wr(2, 16'hABCD);
        wr(0, 16'h000F);
        wr(1, 16'h0003);
        idle(4);
        rd_chk(2, 16'h000D, "R3 tx write mask");
        wr(1, 16'h0000);
        wr(2, 16'h1234);
        wr(0, 16'h0007);
        wr(1, 16'h0003);
        idle(4);
        rd_chk(2, 16'h0034, "R3 rx store mask");
        wr(0, 16'h000F);
    endtask

    task automatic t_stall();
        for (int i = 0; i < 8; i++) wr(2, 16'h2000 + 16'(i));
        for (int i = 0; i < 8; i++) wr(2, 16'h3000 + 16'(i));
        idle(4);
        rd_chk(3, 16'h001C, "R8 stalled both full");
        rd_chk(2, 16'h2000, "R8 R13 first");
        idle(3);
        rd_chk(3, 16'h001E, "R8 one resumed");
        for (int i = 1; i < 8; i++) rd_chk(2, 16'h2000 + 16'(i), "R13 order A");
        for (int i = 0; i < 8; i++) rd_chk(2, 16'h3000 + 16'(i), "R8 R13 order B");
        rd_chk(3, 16'h0003, "R10 all empty");
    endtask

    task automatic t_ext();
        resp_on = 1'b0;
        wr(1, 16'h0002);
        wr(2, 16'h5A5A);
        idle(4);
        chk("R5 request held", {15'd0, frm_req}, 16'h0001);
        chk("R5 frame word", frm_tx, 16'h5A5A);
        rd_chk(3, 16'h0003, "R5 nothing received yet");
        resp_on = 1'b1;
        idle(4);
        chk("R5 request released", {15'd0, frm_req}, 16'h0000);
        rd_chk(2, 16'hA5A5, "R5 returned word");
        wr(0, 16'h0007);
        wr(2, 16'h00C3);
        idle(6);
        rd_chk(2, 16'h003C, "R3 R5 port word masked");
        wr(0, 16'h000F);
    endtask

    task automatic t_irq();
        wr(1, 16'h0000);
        wr(5, 16'h0008);
        idle(1);
        chk("R12 irq tx level", {15'd0, irq}, 16'h0001);
        rd_chk(7, 16'h0008, "R12 masked tx");
        wr(5, 16'h0004);
        idle(1);
        chk("R12 irq masked off", {15'd0, irq}, 16'h0000);
        rd_chk(7, 16'h0000, "R12 masked none");
        wr(1, 16'h0003);
        for (int i = 0; i < 4; i++) wr(2, 16'h4000 + 16'(i));
        idle(6);
        rd_chk(6, 16'h000C, "R11 raw rx at 4");
        chk("R12 irq rx level", {15'd0, irq}, 16'h0001);
        rd_chk(7, 16'h0004, "R12 masked rx");
        for (int i = 0; i < 4; i++) rd_chk(2, 16'h4000 + 16'(i), "R13 drain");
        idle(1);
        chk("R12 irq cleared", {15'd0, irq}, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_disabled();
        t_loop();
        t_mask();
        t_stall();
        t_ext();
        t_irq();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule